// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block sits on the controller side of a four-bank double-data-rate SDRAM. It takes one access request at a time and turns it into the command stream the device needs. A request carries read or write, bank, row, starting column and an auto-precharge flag. The block keeps the open row of every bank. It decides whether the access is a row hit, needs an ACTIVE to a closed bank, or needs a PRECHARGE followed by an ACTIVE. It issues at most one registered command per clock. Per-bank down-counters enforce row-to-column delay, row precharge time and minimum row active time. A shared counter enforces the refresh cycle time, and a data-bus counter spaces column commands by the burst duration.

An access with auto precharge is issued as soon as the row-to-column delay has elapsed. The sequencer never sends a PRECHARGE for that bank. It marks the bank closed once both the burst and the minimum active time are over, then applies the precharge time before that bank can be reopened. A refresh request takes over once the current burst is done. The sequencer precharges every open bank, waits for all precharges, issues AUTO REFRESH, and holds off new activations for the refresh cycle time. The burst length is a static input that may be changed only while the block is idle.

Top module: `ddr_bank_seq`

## Requirements
- R1: Exactly one command leaves on `cmd_o` per clock, registered one cycle after the decision. Encodings: 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 AUTO REFRESH. During reset the output is NOP and `req_ready_o` is low. A request to an idle, closed bank presented in cycle p yields ACTIVE in cycle p+1.
- R2: ACTIVE goes only to a closed bank. It carries the requested bank on `cmd_bank_o` and the requested row on `cmd_addr_o`. READ and WRITE go only to a bank whose open row equals the requested row.
- R3: `req_ready_o` is high in the single cycle a request is accepted. In the next cycle, a READ (write=0) or WRITE (write=1) appears with the request's bank, its column zero-extended in `cmd_addr_o`, and its flag on `cmd_ap_o`.
- R4: A column command to a bank comes at least T_RCD cycles after that bank's ACTIVE. When the request is already waiting, the gap is exactly T_RCD.
- R5: Successive column commands are at least B cycles apart, where B is 1, 2 or 4 for `burst_len_i` 0, 1, and 2 or 3 (burst of 2, 4, 8). Back-to-back hits are exactly B apart.
- R6: On a row miss, the block sends PRECHARGE no earlier than T_RAS after the bank's ACTIVE and no earlier than B after its last column command. It then sends ACTIVE exactly T_RP later and the column command exactly T_RCD after that. `req_ready_o` stays low until the column command.
- R7: After a column command with auto precharge, no PRECHARGE is sent to that bank. The bank may be reactivated no earlier than max(column+B, ACTIVE+T_RAS)+T_RP, and exactly then when a request is waiting for it.
- R8: An auto-precharge access is issued at ACTIVE+T_RCD even when T_RAS exceeds T_RCD.
- R9: AUTO REFRESH is sent only when every bank is closed and its precharge time has elapsed. The block precharges open banks itself. No ACTIVE or further refresh follows within T_RFC cycles.
- R10: While `ref_req_i` is high, no request is accepted, and AUTO REFRESH is issued within a bounded time.
- R11: Banks are independent: activating and accessing one bank leaves the open row of another bank untouched, so a later hit there needs no PRECHARGE or ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, commands issued on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| burst_len_i | input | 2 | Static burst length select: 0=2, 1=4, 2/3=8 |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W (2) | Target bank |
| req_row_i | input | ROW_W (13) | Target row |
| req_col_i | input | COL_W (10) | Starting column |
| req_ap_i | input | 1 | Close the row after this burst |
| ref_req_i | input | 1 | Refresh wanted, held until AUTO REFRESH is seen |
| cmd_o | output | 3 | Command code |
| cmd_bank_o | output | BANK_W (2) | Command bank |
| cmd_addr_o | output | ADDR_W (13) | Row for ACTIVE, column for READ/WRITE, else 0 |
| cmd_ap_o | output | 1 | Auto-precharge flag of READ/WRITE |

## Verification
The embedded properties check on every clock that ACTIVE only targets a closed, precharged bank. They also check that column commands respect the row-to-column delay and the burst spacing, that PRECHARGE waits for the active time and the bank's own burst, and that an auto-precharging bank never gets an explicit PRECHARGE. Further properties check that refresh only starts with every bank closed and that no request is accepted while refresh is wanted. Only the bench scenarios can show that the emitted command carries the accepted request's fields and that gaps are exactly minimal rather than merely legal. The same holds for the miss sequence running in order, the auto-precharge reopen time, untouched neighbour banks, and refresh actually completing.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  // data-bus clocks occupied by one burst, minus one
  function automatic logic [1:0] burst_last(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/ddr_burst_timer.sv
module ddr_burst_timer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] last_i,
  output logic       idle_o
);

  logic [1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= last_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 2'd1;
  end

  assign idle_o = (cnt_q == '0);

  p_burst_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q == '0);

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
  parameter int ROW_W = 13,
  parameter int CNT_W = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             col_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [1:0]       burst_last_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             col_ok_o,
  output logic             pre_ok_o,
  output logic             act_ok_o
);

  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RAS_LD = CNT_W'(T_RAS - 1);

  logic             open_q, ap_pend_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] rcd_q, rp_q, ras_q;
  logic [1:0]       col_q;
  logic             ap_close;

  // self-timed precharge: burst drained and active time met
  assign ap_close = ap_pend_q && (col_q == '0) && (ras_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      ap_pend_q <= 1'b0;
      row_q     <= '0;
      rcd_q     <= '0;
      rp_q      <= '0;
      ras_q     <= '0;
      col_q     <= '0;
    end else begin
      if (act_i)              rcd_q <= RCD_LD;
      else if (rcd_q != '0)   rcd_q <= rcd_q - 1'b1;

      if (act_i)              ras_q <= RAS_LD;
      else if (ras_q != '0)   ras_q <= ras_q - 1'b1;

      if (pre_i || ap_close)  rp_q <= RP_LD;
      else if (rp_q != '0)    rp_q <= rp_q - 1'b1;

      if (col_i)              col_q <= burst_last_i;
      else if (col_q != '0)   col_q <= col_q - 2'd1;

      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (pre_i || ap_close) begin
        open_q <= 1'b0;
      end

      if (col_i && ap_i)      ap_pend_q <= 1'b1;
      else if (ap_close)      ap_pend_q <= 1'b0;
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign col_ok_o = open_q && !ap_pend_q && (rcd_q == '0);
  assign pre_ok_o = open_q && !ap_pend_q && (ras_q == '0) && (col_q == '0);
  assign act_ok_o = !open_q && (rp_q == '0);

  p_act_closed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_q && rp_q == '0);
  p_col_rcd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_i |-> open_q && rcd_q == '0);
  p_pre_ras_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> open_q && ras_q == '0 && col_q == '0);
  p_ap_no_pre_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_pend_q |-> !pre_i && !col_i);

endmodule

// File: rtl/ddr_bank_seq.sv
module ddr_bank_seq #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 7,
  parameter int T_RFC     = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        burst_len_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_ap_i,
  input  logic              ref_req_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              cmd_ap_o
);
  import ddr_seq_pkg::*;

  localparam int T_MAX = (T_RAS > T_RFC) ? T_RAS : T_RFC;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 1);

  logic [NUM_BANKS-1:0] open_v, col_ok_v, pre_ok_v, act_ok_v;
  logic [NUM_BANKS-1:0] act_v, pre_v, col_v;
  logic [ROW_W-1:0]     row_v [NUM_BANKS];

  logic [1:0]        bl_last;
  logic              bus_idle, all_idle, hit;
  logic              do_act, do_pre, do_col, do_ref;
  logic              pre_any;
  logic [BANK_W-1:0] pre_sel, pre_bank;
  logic [CNT_W-1:0]  rfc_q;

  cmd_e              cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ap_q;

  assign bl_last  = burst_last(burst_len_i);
  assign all_idle = &act_ok_v;
  assign hit      = open_v[req_bank_i] && (row_v[req_bank_i] == req_row_i);

  ddr_burst_timer u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (do_col),
    .last_i  (bl_last),
    .idle_o  (bus_idle)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_v[b] = do_act && (req_bank_i == BANK_W'(b));
    assign col_v[b] = do_col && (req_bank_i == BANK_W'(b));
    assign pre_v[b] = do_pre && (pre_bank == BANK_W'(b));

    ddr_bank_track #(
      .ROW_W (ROW_W),
      .CNT_W (CNT_W),
      .T_RCD (T_RCD),
      .T_RP  (T_RP),
      .T_RAS (T_RAS)
    ) u_trk (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .act_i        (act_v[b]),
      .pre_i        (pre_v[b]),
      .col_i        (col_v[b]),
      .ap_i         (req_ap_i),
      .row_i        (req_row_i),
      .burst_last_i (bl_last),
      .open_o       (open_v[b]),
      .row_o        (row_v[b]),
      .col_ok_o     (col_ok_v[b]),
      .pre_ok_o     (pre_ok_v[b]),
      .act_ok_o     (act_ok_v[b])
    );
  end

  // lowest bank that may be closed, used while draining for refresh
  always_comb begin
    pre_any = 1'b0;
    pre_sel = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (!pre_any && pre_ok_v[i]) begin
        pre_any = 1'b1;
        pre_sel = BANK_W'(i);
      end
    end
  end

  always_comb begin
    do_act   = 1'b0;
    do_pre   = 1'b0;
    do_col   = 1'b0;
    do_ref   = 1'b0;
    pre_bank = req_bank_i;
    if (ref_req_i) begin
      if (bus_idle) begin
        if (pre_any) begin
          do_pre   = 1'b1;
          pre_bank = pre_sel;
        end else if (all_idle && rfc_q == '0) begin
          do_ref = 1'b1;
        end
      end
    end else if (req_valid_i) begin
      if (hit) begin
        do_col = col_ok_v[req_bank_i] && bus_idle;
      end else if (open_v[req_bank_i]) begin
        do_pre = pre_ok_v[req_bank_i];
      end else begin
        do_act = act_ok_v[req_bank_i] && (rfc_q == '0);
      end
    end
  end

  assign req_ready_o = do_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rfc_q <= '0;
    else if (do_ref)        rfc_q <= RFC_LD;
    else if (rfc_q != '0)   rfc_q <= rfc_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
    end else begin
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
      if (do_act) begin
        cmd_q  <= CMD_ACT;
        bank_q <= req_bank_i;
        addr_q <= ADDR_W'(req_row_i);
      end else if (do_col) begin
        cmd_q  <= req_write_i ? CMD_WR : CMD_RD;
        bank_q <= req_bank_i;
        addr_q <= ADDR_W'(req_col_i);
        ap_q   <= req_ap_i;
      end else if (do_pre) begin
        cmd_q  <= CMD_PRE;
        bank_q <= pre_bank;
      end else if (do_ref) begin
        cmd_q  <= CMD_REF;
      end else begin
        cmd_q  <= CMD_NOP;
      end
    end
  end

  assign cmd_o      = cmd_q;
  assign cmd_bank_o = bank_q;
  assign cmd_addr_o = addr_q;
  assign cmd_ap_o   = ap_q;

  p_ref_all_closed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_ref |-> open_v == '0);
  p_ref_blocks_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_i |-> !req_ready_o);
  p_rfc_no_act_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_REF) |-> act_v == '0);

endmodule

// File: tb/ddr_bank_seq_test.sv
module ddr_bank_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 3;
  localparam int T_RP  = 3;
  localparam int T_RAS = 7;
  localparam int T_RFC = 10;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        burst_len = 2'd1;
  logic              req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
  logic [1:0]        req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic              ref_req = 1'b0;
  logic              req_ready;
  logic [2:0]        cmd;
  logic [1:0]        cmd_bank;
  logic [12:0]       cmd_addr;
  logic              cmd_ap;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_bank_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RFC(T_RFC),
                 .ROW_W(ROW_W), .COL_W(COL_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .burst_len_i(burst_len),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_ap_i(req_ap), .ref_req_i(ref_req), .cmd_o(cmd), .cmd_bank_o(cmd_bank),
    .cmd_addr_o(cmd_addr), .cmd_ap_o(cmd_ap)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mon_en = 0, saw_ref = 0;
  bit b_open [4];
  int b_row [4], t_act [4], t_col [4], t_pre [4], act_ok_at [4];
  int last_col = -1000, ref_ok_at = 0;
  bit pend = 0, e_w = 0, e_ap = 0;
  int e_b = 0, e_row = 0, e_col = 0;

  function automatic int bl_clk(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic monitor();
    int b, bl;
    b  = int'(cmd_bank);
    bl = bl_clk(burst_len);
    if (pend && !(cmd == 3'd2 || cmd == 3'd3))
      chk(0, "R3 column after accept", int'(cmd), e_w ? 3 : 2);
    case (cmd)
      3'd1: begin
        chk(!b_open[b], "R2 ACTIVE to closed bank", int'(b_open[b]), 0);
        chk(cyc >= act_ok_at[b], "R7/R6 ACTIVE after tRP", cyc, act_ok_at[b]);
        chk(cyc >= ref_ok_at, "R9 ACTIVE after tRFC", cyc, ref_ok_at);
        chk(req_valid && int'(req_bank) == b && int'(cmd_addr) == int'(req_row),
            "R2 ACTIVE bank/row", int'(cmd_addr), int'(req_row));
        b_open[b] = 1; b_row[b] = int'(cmd_addr); t_act[b] = cyc;
      end
      3'd2, 3'd3: begin
        chk(pend, "R3 column without accept", 1, 0);
        chk(b_open[b] && b_row[b] == e_row, "R2 column to open matching row", b_row[b], e_row);
        chk(cyc - t_act[b] >= T_RCD, "R4 tRCD", cyc - t_act[b], T_RCD);
        chk(cyc - last_col >= bl, "R5 burst gap", cyc - last_col, bl);
        chk(b == e_b && int'(cmd_addr) == e_col && cmd_ap == e_ap && (cmd == 3'd3) == e_w,
            "R3 column fields", int'(cmd_addr), e_col);
        last_col = cyc; t_col[b] = cyc; pend = 0;
        if (cmd_ap) begin
          act_ok_at[b] = imax(cyc + bl, t_act[b] + T_RAS) + T_RP;
          b_open[b] = 0;
        end
      end
      3'd4: begin
        chk(b_open[b], "R7 PRECHARGE only to open bank", int'(b_open[b]), 1);
        chk(cyc - t_act[b] >= T_RAS, "R6 tRAS", cyc - t_act[b], T_RAS);
        chk(cyc - t_col[b] >= bl, "R6 burst done", cyc - t_col[b], bl);
        b_open[b] = 0; t_pre[b] = cyc; act_ok_at[b] = cyc + T_RP;
      end
      3'd5: begin
        for (int i = 0; i < 4; i++) begin
          chk(!b_open[i], "R9 REF with bank open", i, -1);
          chk(cyc >= act_ok_at[i], "R9 REF after tRP", cyc, act_ok_at[i]);
        end
        chk(cyc >= ref_ok_at, "R9 REF spacing", cyc, ref_ok_at);
        chk(ref_req, "R9 REF unrequested", 0, 1);
        ref_ok_at = cyc + T_RFC; saw_ref = 1;
      end
      default: ;
    endcase
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (mon_en) monitor();
  endtask

  task automatic note_accept();
    pend = 1; e_w = req_write; e_b = int'(req_bank); e_row = int'(req_row);
    e_col = int'(req_col); e_ap = req_ap;
  endtask

  task automatic send(input bit w, input int b, input int row, input int col, input bit ap,
                      output int t_pres);
    int n;
    req_write = w; req_bank = 2'(b); req_row = ROW_W'(row); req_col = COL_W'(col);
    req_ap = ap; req_valid = 1; t_pres = cyc; n = 0;
    forever begin
      #1;
      if (ref_req && req_ready) chk(0, "R10 accept during refresh", 1, 0);
      if (req_ready) begin note_accept(); break; end
      tick(); n++;
      if (n > 300) begin chk(0, "R3 request never accepted", n, 0); req_valid = 0; return; end
    end
    tick();
    req_valid = 0;
  endtask

  task automatic do_refresh();
    int n = 0;
    ref_req = 1; saw_ref = 0;
    while (!saw_ref && n < 200) begin
      #1;
      chk(!req_ready, "R10 ready low in refresh", int'(req_ready), 0);
      tick(); n++;
    end
    chk(saw_ref, "R10 refresh served", n, 200);
    ref_req = 0;
  endtask

  task automatic drain();
    req_valid = 0; ref_req = 0;
    repeat (20) tick();
  endtask

  task automatic rand_phase(input int n_cyc);
    int wt = 0, rw = 0;
    for (int i = 0; i < n_cyc; i++) begin
      if (!req_valid && ($urandom % 3) == 0) begin
        req_write = 1'($urandom); req_bank = 2'($urandom); req_row = ROW_W'($urandom % 3);
        req_col = COL_W'($urandom); req_ap = (($urandom % 4) == 0);
        req_valid = 1; wt = 0;
      end
      if (!ref_req && ($urandom % 80) == 0) begin ref_req = 1; saw_ref = 0; rw = 0; end
      #1;
      if (ref_req && req_ready) chk(0, "R10 accept during refresh", 1, 0);
      if (req_valid && req_ready) note_accept();
      tick();
      if (pend == 0 && req_valid && req_ready === 1'b0 && wt > 300)
        begin chk(0, "R3 random request starved", wt, 300); req_valid = 0; end
      if (req_valid) wt++;
      if (e_b == int'(req_bank) && !pend && wt > 0 && cmd != 3'd0 && (cmd == 3'd2 || cmd == 3'd3)
          && e_col == int'(req_col)) req_valid = 0;
      if (ref_req) begin
        rw++;
        if (saw_ref) ref_req = 0;
        else if (rw > 200) begin chk(0, "R10 refresh starved", rw, 200); ref_req = 0; end
      end
    end
    drain();
  endtask

  initial begin
    int p0, a0, c0, a1, tp;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin
      b_open[i] = 0; b_row[i] = 0; t_act[i] = -1000; t_col[i] = -1000;
      t_pre[i] = -1000; act_ok_at[i] = 0;
    end
    req_valid = 1; req_bank = 2'd0;
    repeat (3) begin
      tick();
      chk(cmd == 3'd0, "R1 reset NOP", int'(cmd), 0);
      chk(!req_ready, "R1 reset ready low", int'(req_ready), 0);
    end
    req_valid = 0;
    rst_ni = 1;
    tick();
    chk(cmd == 3'd0, "R1 idle NOP", int'(cmd), 0);
    mon_en = 1;

    // burst of 4: auto-precharge read opened early, then reopen
    burst_len = 2'd1;
    send(0, 0, 5, 17, 1, p0);
    chk(t_act[0] == p0 + 1, "R1 ACTIVE latency", t_act[0], p0 + 1);
    chk(t_col[0] - t_act[0] == T_RCD, "R8 early auto-precharge column", t_col[0] - t_act[0], T_RCD);
    a0 = t_act[0]; c0 = t_col[0];
    send(1, 0, 6, 2, 0, tp);
    chk(t_act[0] == imax(c0 + 2, a0 + T_RAS) + T_RP, "R7 reopen after auto precharge",
        t_act[0], imax(c0 + 2, a0 + T_RAS) + T_RP);
    chk(t_pre[0] < 0, "R7 no explicit PRECHARGE", t_pre[0], -1000);

    // independent banks
    a0 = t_act[0];
    send(1, 2, 9, 3, 0, tp);
    send(0, 0, 6, 4, 0, tp);
    chk(t_act[0] == a0, "R11 bank0 row kept", t_act[0], a0);
    chk(t_pre[0] < 0, "R11 no PRECHARGE on bank0", t_pre[0], -1000);

    // row miss
    send(0, 1, 2, 5, 0, tp);
    a1 = t_act[1];
    chk(t_col[1] - a1 == T_RCD, "R4 exact tRCD", t_col[1] - a1, T_RCD);
    send(0, 1, 3, 6, 0, tp);
    chk(t_pre[1] == a1 + T_RAS, "R6 PRECHARGE at tRAS", t_pre[1], a1 + T_RAS);
    chk(t_act[1] == t_pre[1] + T_RP, "R6 ACTIVE after tRP", t_act[1], t_pre[1] + T_RP);
    chk(t_col[1] == t_act[1] + T_RCD, "R6 column after tRCD", t_col[1], t_act[1] + T_RCD);

    // refresh with banks open
    do_refresh();
    for (int i = 0; i < 4; i++) chk(!b_open[i], "R9 banks closed by refresh", i, -1);
    drain();

    // burst of 8: back-to-back hits
    burst_len = 2'd2;
    send(0, 3, 1, 8, 0, tp);
    c0 = t_col[3];
    send(0, 3, 1, 12, 0, tp);
    chk(t_col[3] - c0 == 4, "R5 exact burst-8 gap", t_col[3] - c0, 4);
    drain();

    burst_len = 2'd0; rand_phase(1500);
    burst_len = 2'd1; rand_phase(1500);
    burst_len = 2'd2; rand_phase(1500);
    burst_len = 2'd3; rand_phase(800);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog R1: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule